// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Lock

The block is a register-mapped watchdog. Software programs a tick count into a timer register and then writes the reload register, which loads the countdown from that value. The count falls by one on each cycle in which `tick_en` is high and the halt bit is clear. In the intended system each tick is 0.6 s, so software converts a timeout in seconds to ticks as seconds × 10 / 6. When the count runs out, the block sets a timeout status flag, loads the timer value again and keeps counting.

The block remembers whether an expiry has already happened since the last software reload. If the counter runs out a second time with no reload in between, the block sets a second-timeout flag. Unless the `no_reboot` strap is high, it also raises a one-cycle system-reset request. A lock bit, once set, stays set until hardware reset.

Register read and write use separate address ports with a shared 16-bit data width. A read is combinational from `rd_addr`. A write takes effect at the clock edge where `wr_en` is high.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, the register reads are: reload (address 0) reads 0, timer (address 1) reads 0x0004, control one (address 2) reads 0x0000, control two (address 3) reads 0x0008, and both status registers (addresses 4 and 5) read 0x0000.
- R2: The timer register keeps only its low 10 bits. Writing 0xFFFF to address 1 reads back as 0x03FF.
- R3: Any write to address 0 loads the countdown from the timer register. Reading address 0 returns the live count. The count drops by one on each clock edge where `tick_en` is high and halt is clear. A count of zero is idle and does not decrement.
- R4: With a loaded count N, the count reads 1 after N−1 ticks and status bit 3 of address 4 is still clear. The Nth tick sets that bit and reloads the count to the timer value.
- R5: Status bit 3 of address 4 and status bit 1 of address 5 are write-one-to-clear. Writing 0 to them has no effect.
- R6: A second expiry with no reload to address 0 since the previous expiry sets bit 1 of address 5. This happens even if bit 3 of address 4 was cleared in between.
- R7: On a second expiry, `rst_req` is high for exactly one cycle if `no_reboot` is low. It stays low if `no_reboot` is high.
- R8: A write to address 0 discards the expiry history, so the next expiry is treated as a first expiry only.
- R9: Bit 0 of address 2 (halt) freezes the count while it is set. Clearing it resumes the countdown from the frozen value.
- R10: Bit 1 of address 2 (lock) is set by writing 1 and cannot be cleared by any write. Only reset clears it. The halt bit stays writable while lock is set.
- R11: Reserved bits read as zero and ignore writes. Control two holds a 4-bit field in bits 3:0. Addresses 6 and 7 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One countdown tick per high cycle |
| no_reboot | input | 1 | Strap that suppresses the reset request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 16 | Combinational read data |
| rst_req | output | 1 | One-cycle system-reset request |

## Verification
The assertions assume that `tick_en`, `no_reboot` and the write strobe are driven synchronously and are stable at each clock edge. They also assume that only one register is written per cycle, which the single write port guarantees. The stimulus changes every input at the falling edge, away from the edge where the registers sample. It raises `tick_en` only through a task that counts ticks exactly, so every expected count follows from the number of ticks issued. The `no_reboot` strap is changed only while the counter is idle or between expiries, never in the cycle of an expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int DATA_W  = 16;
    localparam int TMR_W   = 10;
    localparam int ADDR_W  = 3;
    localparam int CTRL2_W = 4;

    localparam logic [TMR_W-1:0]   TMR_RST   = TMR_W'(4);
    localparam logic [CTRL2_W-1:0] CTRL2_RST = CTRL2_W'(8);

    localparam int HALT_BIT   = 0;
    localparam int LOCK_BIT   = 1;
    localparam int FIRST_BIT  = 3;
    localparam int SECOND_BIT = 1;

    typedef enum logic [ADDR_W-1:0] {
        A_RELOAD = 3'd0,
        A_TIMER  = 3'd1,
        A_CTRL1  = 3'd2,
        A_CTRL2  = 3'd3,
        A_STS1   = 3'd4,
        A_STS2   = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic lock;
        logic halt;
    } ctrl1_t;

    typedef struct packed {
        logic second_to;
        logic first_to;
    } sts_t;

    function automatic logic [DATA_W-1:0] put_bit(input logic v, input int pos);
        logic [DATA_W-1:0] r;
        r = '0;
        r[pos] = v;
        return r;
    endfunction

endpackage

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int TW = TMR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_en,
    input  logic          halt,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic [TW-1:0] cnt,
    output logic          expire
);

    localparam logic [TW-1:0] ONE = TW'(1);

    logic step;

    assign step   = tick_en && !halt && !load && (cnt != '0);
    assign expire = step && (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (step) begin
            cnt <= expire ? load_val : cnt - ONE;
        end
    end

endmodule

// File: rtl/wdog_stage.sv
module wdog_stage (
    input  logic clk,
    input  logic rst,
    input  logic expire,
    input  logic clear,
    input  logic no_reboot,
    output logic set_first,
    output logic set_second,
    output logic rst_req
);

    logic seen;

    assign set_first  = expire;
    assign set_second = expire && seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen    <= 1'b0;
            rst_req <= 1'b0;
        end else begin
            if (clear) begin
                seen <= 1'b0;
            end else if (expire) begin
                seen <= 1'b1;
            end
            rst_req <= set_second && !no_reboot;
        end
    end

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int TW = TMR_W,
    parameter int AW = ADDR_W,
    parameter int CW = CTRL2_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic [TW-1:0] cnt,
    input  logic          set_first,
    input  logic          set_second,
    output logic          load,
    output logic [TW-1:0] tmr_val,
    output ctrl1_t        ctrl1,
    output sts_t          sts
);

    logic [CW-1:0] ctrl2;
    logic wr_tmr, wr_c1, wr_c2, clr_first, clr_second;

    assign load       = wr_en && (wr_addr == A_RELOAD);
    assign wr_tmr     = wr_en && (wr_addr == A_TIMER);
    assign wr_c1      = wr_en && (wr_addr == A_CTRL1);
    assign wr_c2      = wr_en && (wr_addr == A_CTRL2);
    assign clr_first  = wr_en && (wr_addr == A_STS1) && wr_data[FIRST_BIT];
    assign clr_second = wr_en && (wr_addr == A_STS2) && wr_data[SECOND_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            tmr_val <= TMR_RST;
            ctrl1   <= '0;
            ctrl2   <= CTRL2_RST;
            sts     <= '0;
        end else begin
            if (wr_tmr) begin
                tmr_val <= wr_data[TW-1:0];
            end
            if (wr_c1) begin
                ctrl1.halt <= wr_data[HALT_BIT];
                ctrl1.lock <= ctrl1.lock | wr_data[LOCK_BIT];
            end
            if (wr_c2) begin
                ctrl2 <= wr_data[CW-1:0];
            end
            sts.first_to  <= set_first  | (sts.first_to  & ~clr_first);
            sts.second_to <= set_second | (sts.second_to & ~clr_second);
        end
    end

    always_comb begin
        rd_data = '0;
        case (rd_addr)
            A_RELOAD: rd_data = {{(DW-TW){1'b0}}, cnt};
            A_TIMER:  rd_data = {{(DW-TW){1'b0}}, tmr_val};
            A_CTRL1:  rd_data = put_bit(ctrl1.halt, HALT_BIT) | put_bit(ctrl1.lock, LOCK_BIT);
            A_CTRL2:  rd_data = {{(DW-CW){1'b0}}, ctrl2};
            A_STS1:   rd_data = put_bit(sts.first_to, FIRST_BIT);
            A_STS2:   rd_data = put_bit(sts.second_to, SECOND_BIT);
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdog_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_en,
    input  logic              no_reboot,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rst_req
);

    logic [TMR_W-1:0] cnt_w;
    logic [TMR_W-1:0] tmr_w;
    logic             load_w;
    logic             expire_w;
    logic             set_first_w;
    logic             set_second_w;
    ctrl1_t           ctrl1_w;
    sts_t             sts_w;

    wdog_regs #(
        .DW(DATA_W), .TW(TMR_W), .AW(ADDR_W), .CW(CTRL2_W)
    ) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .cnt        (cnt_w),
        .set_first  (set_first_w),
        .set_second (set_second_w),
        .load       (load_w),
        .tmr_val    (tmr_w),
        .ctrl1      (ctrl1_w),
        .sts        (sts_w)
    );

    wdog_counter #(.TW(TMR_W)) u_counter (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .halt     (ctrl1_w.halt),
        .load     (load_w),
        .load_val (tmr_w),
        .cnt      (cnt_w),
        .expire   (expire_w)
    );

    wdog_stage u_stage (
        .clk        (clk),
        .rst        (rst),
        .expire     (expire_w),
        .clear      (load_w),
        .no_reboot  (no_reboot),
        .set_first  (set_first_w),
        .set_second (set_second_w),
        .rst_req    (rst_req)
    );

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
    parameter int TW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic          tick_en,
    input logic          no_reboot,
    input logic          halt,
    input logic          lock,
    input logic          load,
    input logic [TW-1:0] cnt,
    input logic          expire,
    input logic          sts_first,
    input logic          sts_second,
    input logic          rst_req
);

    assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tick_en && !halt && !load && cnt > TW'(1)) |=> cnt == $past(cnt) - TW'(1));

    assert_first_flag_R4: assert property (@(posedge clk) disable iff (rst)
        expire |=> sts_first);

    assert_second_flag_R6: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> sts_second);

    assert_pulse_width_R7: assert property (@(posedge clk) disable iff (rst)
        rst_req |=> !rst_req);

    assert_strap_gate_R7: assert property (@(posedge clk) disable iff (rst)
        rst_req |-> !$past(no_reboot));

    assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (rst)
        (halt && !load) |=> $stable(cnt));

    assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        lock |=> lock);

endmodule

bind wdog_two_stage wdog_checker #(.TW(wdog_pkg::TMR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick_en    (tick_en),
    .no_reboot  (no_reboot),
    .halt       (ctrl1_w.halt),
    .lock       (ctrl1_w.lock),
    .load       (load_w),
    .cnt        (cnt_w),
    .expire     (expire_w),
    .sts_first  (sts_w.first_to),
    .sts_second (sts_w.second_to),
    .rst_req    (rst_req)
);

// File: tb/wdog_two_stage_bench.sv
module wdog_two_stage_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_en = 1'b0;
    logic        no_reboot = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        rst_req;

    int total = 0;
    int bad = 0;
    int pulses = 0;

    always #10 clk = ~clk;

    wdog_two_stage u_wdog_two_stage (
        .clk       (clk),
        .rst       (rst),
        .tick_en   (tick_en),
        .no_reboot (no_reboot),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .rst_req   (rst_req)
    );

    always @(posedge clk) if (!rst && rst_req) pulses <= pulses + 1;

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got=0x%0h expected=0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        rd_addr = 3'(a);
        #1;
        d = int'(rd_data);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            tick_en = 1'b1;
            @(negedge clk);
        end
        tick_en = 1'b0;
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got=hang expected=finish");
        summary();
        $finish;
    end

    initial begin
        int v;
        int p0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset values
        rd(0, v); chk("R1 reload", v, 0);
        rd(1, v); chk("R1 timer", v, 4);
        rd(2, v); chk("R1 ctrl1", v, 0);
        rd(3, v); chk("R1 ctrl2", v, 8);
        rd(4, v); chk("R1 sts1", v, 0);
        rd(5, v); chk("R1 sts2", v, 0);
        // R3: zero count stays idle
        tick(3);
        rd(0, v); chk("R3 idle", v, 0);
        rd(4, v); chk("R3 idle sts", v, 0);

        // R11 reserved bits
        rd(6, v); chk("R11 addr6", v, 0);
        rd(7, v); chk("R11 addr7", v, 0);
        wr(3, 16'hFFFF); rd(3, v); chk("R11 ctrl2 mask", v, 16'h000F);
        wr(3, 16'h0008);
        wr(2, 16'hFFFC); rd(2, v); chk("R11 ctrl1 reserved", v, 0);
        wr(4, 16'hFFFF); rd(4, v); chk("R11 sts1", v, 0);
        wr(5, 16'hFFFF); rd(5, v); chk("R11 sts2", v, 0);

        // R2 masking
        wr(1, 16'hFFFF); rd(1, v); chk("R2 mask", v, 16'h03FF);

        // R4/R8 sweep over loaded counts
        for (int n = 1; n <= 12; n++) begin
            wr(1, n);
            wr(0, 0);
            wr(4, 16'h0008);
            rd(0, v); chk("R3 load", v, n);
            for (int k = 1; k < n; k++) begin
                tick(1);
                rd(0, v); chk("R3 step", v, n - k);
                rd(4, v); chk("R4 early", v, 0);
            end
            tick(1);
            rd(4, v); chk("R4 flag", v, 16'h0008);
            rd(0, v); chk("R4 reload", v, n);
            rd(5, v); chk("R8 first only", v, 0);
        end

        // R5 write-one-to-clear
        wr(4, 0); rd(4, v); chk("R5 zero write", v, 16'h0008);
        wr(4, 16'h0008); rd(4, v); chk("R5 clear", v, 0);

        // R6 second expiry with no_reboot high
        no_reboot = 1'b1;
        p0 = pulses;
        wr(1, 3); wr(0, 0);
        tick(3);
        rd(5, v); chk("R6 after first", v, 0);
        wr(4, 16'h0008);
        tick(3);
        rd(5, v); chk("R6 second", v, 16'h0002);
        rd(4, v); chk("R6 first again", v, 16'h0008);
        chk("R7 strap blocks", pulses, p0);
        wr(5, 0); rd(5, v); chk("R5 sts2 zero write", v, 16'h0002);
        wr(5, 16'h0002); rd(5, v); chk("R5 sts2 clear", v, 0);

        // R7 reset pulse with no_reboot low
        wr(4, 16'h0008);
        wr(1, 2); wr(0, 0);
        no_reboot = 1'b0;
        p0 = pulses;
        tick(2);
        chk("R7 no pulse first", int'(rst_req), 0);
        tick(1);
        chk("R7 not yet", int'(rst_req), 0);
        tick(1);
        chk("R7 pulse high", int'(rst_req), 1);
        @(negedge clk);
        chk("R7 pulse low", int'(rst_req), 0);
        chk("R7 one pulse", pulses - p0, 1);

        // R8 reload between expiries
        wr(5, 16'h0002); wr(4, 16'h0008);
        p0 = pulses;
        wr(1, 4); wr(0, 0);
        tick(4);
        wr(0, 0);
        tick(4);
        rd(5, v); chk("R8 history cleared", v, 0);
        chk("R8 no pulse", pulses, p0);
        no_reboot = 1'b1;

        // R9 halt
        wr(1, 5); wr(0, 0);
        wr(2, 16'h0001);
        tick(3);
        rd(0, v); chk("R9 frozen", v, 5);
        wr(2, 0);
        tick(2);
        rd(0, v); chk("R9 resume", v, 3);

        // R10 lock
        wr(2, 16'h0002); rd(2, v); chk("R10 set", v, 2);
        wr(2, 0);        rd(2, v); chk("R10 sticky", v, 2);
        wr(2, 16'h0001); rd(2, v); chk("R10 halt writable", v, 3);
        wr(2, 0);        rd(2, v); chk("R10 halt clear", v, 2);

        // R2/R4 maximum count
        wr(4, 16'h0008); wr(5, 16'h0002);
        wr(1, 16'hFFFF); wr(0, 0);
        tick(1022);
        rd(0, v); chk("R4 max one left", v, 1);
        rd(4, v); chk("R4 max no flag", v, 0);
        tick(1);
        rd(4, v); chk("R4 max flag", v, 16'h0008);
        rd(0, v); chk("R2 max reload", v, 16'h03FF);

        summary();
        $finish;
    end

endmodule